// File: doc/BRIEF.md
# Pipelined Tower-Field AES Byte Substitution

This block performs the AES forward byte substitution on one byte per clock, using gates only. The byte is first carried by a linear change of basis into a three-level tower field, GF(((2^2)^2)^2). It is inverted there with small GF(2^4) and GF(2^2) operators. A second linear map then brings the inverse back into the AES polynomial basis, and the same map applies the affine step.

Registers sit inside the inversion datapath to shorten the longest combinational path. The first register follows the basis change and the GF(2^4) norm computation, the second follows the GF(2^4) inversion, and the third is the output register. A valid flag travels with each byte. Upstream logic can present one byte every cycle, and each result appears a fixed number of cycles later. There is no back-pressure.

Top module: `sbox_tower_pipe`

## Requirements
- R1: `out_byte` equals the AES S-box of the accepted input: the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0x00 mapped to 0x00, followed by b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63. For example 0x00 gives 0x63, 0x53 gives 0xED and 0xFF gives 0x16.
- R2: A byte accepted at a rising edge (`in_vld` high) shows up on `out_byte` with `out_vld` high after exactly three rising edges. `out_vld` stays low after the first and the second of those edges.
- R3: A new byte can be accepted on every edge with no gaps. Results leave in the order the bytes arrived.
- R4: `out_vld` is high in exactly the cycles that match accepted bytes. Cycles with `in_vld` low produce no output.
- R5: A synchronous active-high `rst` sampled at an edge clears every valid flag and sets `out_byte` to 0x00. Bytes in flight at that edge never come out.
- R6: While `out_vld` is low, `out_byte` holds the last result, or 0x00 after reset. `in_byte` is ignored when `in_vld` is low.
- R7: The inversion uses the tower GF(2^2) built with x^2+x+1, GF(2^4) built with x^2+x+φ where φ = 2'b11, and GF(2^8) built with x^2+x+ν where ν = 4'b1010. The GF(2^4) inverse formed in the middle stage times its operand is 1, or both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_vld | output | 1 | Result is present this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench sends all 256 inputs back to back and checks each one against a reference built from a brute-force GF(2^8) power. A wrong basis matrix or a wrong field constant would corrupt most outputs. A zero input is checked on its own, since a design that does not map zero to zero in the norm path would give some value other than 0x63. A lone byte after idle cycles and an irregular bubble pattern expose an off-by-one stage count or a valid flag that runs ahead of its data. A reset raised in the middle of a stream shows whether stale bytes leak out afterwards. It also shows whether the output data moves while no result is flagged.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int DIB_W  = NIB_W / 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [DIB_W-1:0]  dib_t;
  // Column k of a bit matrix holds the image of input bit k.
  typedef logic [BYTE_W-1:0][BYTE_W-1:0] bmat_t;

  // Tower constants: GF(4) with w^2=w+1, GF(16) with z^2=z+PHI, GF(256) with y^2=y+NU.
  localparam dib_t  PHI   = 2'b11;
  localparam nib_t  NU    = 4'b1010;
  localparam byte_t AFF_C = 8'h63;

  function automatic dib_t gf4_mul(input dib_t a, input dib_t b);
    logic t;
    t = a[1] & b[1];
    return {t ^ (a[1] & b[0]) ^ (a[0] & b[1]), t ^ (a[0] & b[0])};
  endfunction

  function automatic dib_t gf4_sq(input dib_t a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic nib_t gf16_mul(input nib_t a, input nib_t b);
    dib_t hh;
    hh = gf4_mul(a[3:2], b[3:2]);
    return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_mul(hh, PHI) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic nib_t gf16_sq(input nib_t a);
    dib_t s1;
    s1 = gf4_sq(a[3:2]);
    return {s1, gf4_mul(s1, PHI) ^ gf4_sq(a[1:0])};
  endfunction

  function automatic nib_t gf16_inv(input nib_t a);
    dib_t nrm;
    dib_t ninv;
    nrm  = gf4_mul(gf4_sq(a[3:2]), PHI) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
    ninv = gf4_sq(nrm);
    return {gf4_mul(a[3:2], ninv), gf4_mul(a[3:2] ^ a[1:0], ninv)};
  endfunction

  function automatic byte_t mat_apply(input bmat_t m, input byte_t v);
    byte_t r;
    r = '0;
    for (int k = 0; k < BYTE_W; k++)
      if (v[3'(k)]) r = r ^ m[3'(k)];
    return r;
  endfunction

  function automatic byte_t affine_lin(input byte_t v);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++)
      r[3'(i)] = v[3'(i)] ^ v[3'(i + 4)] ^ v[3'(i + 5)] ^ v[3'(i + 6)] ^ v[3'(i + 7)];
    return r;
  endfunction

  // Gauss-Jordan over GF(2): keeps (image, preimage) pairs until images are unit vectors.
  function automatic bmat_t mat_invert(input bmat_t m);
    bmat_t img;
    bmat_t pre;
    byte_t tmp;
    int    piv;
    img = m;
    pre = '0;
    for (int k = 0; k < BYTE_W; k++) pre[3'(k)][3'(k)] = 1'b1;
    for (int j = 0; j < BYTE_W; j++) begin
      piv = j;
      for (int r = BYTE_W - 1; r >= j; r--)
        if (img[3'(r)][3'(j)]) piv = r;
      tmp = img[3'(j)]; img[3'(j)] = img[3'(piv)]; img[3'(piv)] = tmp;
      tmp = pre[3'(j)]; pre[3'(j)] = pre[3'(piv)]; pre[3'(piv)] = tmp;
      for (int i = 0; i < BYTE_W; i++)
        if (i != j && img[3'(i)][3'(j)]) begin
          img[3'(i)] = img[3'(i)] ^ img[3'(j)];
          pre[3'(i)] = pre[3'(i)] ^ pre[3'(j)];
        end
    end
    return pre;
  endfunction

  function automatic bmat_t mat_affine(input bmat_t m);
    bmat_t r;
    for (int k = 0; k < BYTE_W; k++) r[3'(k)] = affine_lin(m[3'(k)]);
    return r;
  endfunction

  // Polynomial-basis images of tower basis 1, w, z, wz, y, wy, zy, wzy.
  localparam bmat_t TOWER_TO_POLY = {8'h2B, 8'h09, 8'hE6, 8'h4E, 8'h0D, 8'hE0, 8'hBC, 8'h01};
  localparam bmat_t POLY_TO_TOWER = mat_invert(TOWER_TO_POLY);
  localparam bmat_t TOWER_TO_OUT  = mat_affine(TOWER_TO_POLY);

endpackage

// File: rtl/sbox_map_stage.sv
module sbox_map_stage
  import sbox_tower_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vld_i,
  input  byte_t din,
  output logic  vld_q,
  output nib_t  hi_q,
  output nib_t  lo_q,
  output nib_t  nrm_q
);
  byte_t t;
  nib_t  nrm;

  always_comb begin
    t   = mat_apply(POLY_TO_TOWER, din);
    nrm = gf16_mul(gf16_sq(t[7:4]), NU) ^ gf16_mul(t[7:4], t[3:0]) ^ gf16_sq(t[3:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
      nrm_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        hi_q  <= t[7:4];
        lo_q  <= t[3:0];
        nrm_q <= nrm;
      end
    end
  end

  a_r4_vld_follow: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_q);
  a_r4_vld_drop:   assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_q);
  a_r6_hold_data:  assert property (@(posedge clk) disable iff (rst)
                     !vld_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(nrm_q)));
endmodule

// File: rtl/sbox_inv_stage.sv
module sbox_inv_stage
  import sbox_tower_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  nib_t hi_i,
  input  nib_t lo_i,
  input  nib_t nrm_i,
  output logic vld_q,
  output nib_t hi_q,
  output nib_t lo_q,
  output nib_t ninv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
      ninv_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        hi_q   <= hi_i;
        lo_q   <= lo_i;
        ninv_q <= gf16_inv(nrm_i);
      end
    end
  end

  // R7: the GF(16) inverse really inverts its operand
  a_r7_inv16: assert property (@(posedge clk) disable iff (rst)
                (vld_q && $past(vld_i) && !$past(rst)) |->
                (($past(nrm_i) == 4'h0) ? (ninv_q == 4'h0)
                                        : (gf16_mul($past(nrm_i), ninv_q) == 4'h1)));
  a_r4_vld_follow: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_q);
  a_r4_vld_drop:   assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_q);
endmodule

// File: rtl/sbox_out_stage.sv
module sbox_out_stage
  import sbox_tower_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vld_i,
  input  nib_t  hi_i,
  input  nib_t  lo_i,
  input  nib_t  ninv_i,
  output logic  vld_q,
  output byte_t dout_q
);
  byte_t inv_t;
  byte_t res;

  always_comb begin
    inv_t = {gf16_mul(hi_i, ninv_i), gf16_mul(hi_i ^ lo_i, ninv_i)};
    res   = mat_apply(TOWER_TO_OUT, inv_t) ^ AFF_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) dout_q <= res;
    end
  end

  a_r4_vld_follow: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_q);
  a_r6_hold_data:  assert property (@(posedge clk) disable iff (rst) !vld_i |=> $stable(dout_q));
endmodule

// File: rtl/sbox_tower_pipe.sv
module sbox_tower_pipe
  import sbox_tower_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  output logic       out_vld,
  output logic [7:0] out_byte
);
  logic s1_vld, s2_vld;
  nib_t s1_hi, s1_lo, s1_nrm;
  nib_t s2_hi, s2_lo, s2_ninv;

  sbox_map_stage u_map (
    .clk(clk), .rst(rst), .vld_i(in_vld), .din(in_byte),
    .vld_q(s1_vld), .hi_q(s1_hi), .lo_q(s1_lo), .nrm_q(s1_nrm)
  );

  sbox_inv_stage u_inv (
    .clk(clk), .rst(rst), .vld_i(s1_vld), .hi_i(s1_hi), .lo_i(s1_lo), .nrm_i(s1_nrm),
    .vld_q(s2_vld), .hi_q(s2_hi), .lo_q(s2_lo), .ninv_q(s2_ninv)
  );

  sbox_out_stage u_out (
    .clk(clk), .rst(rst), .vld_i(s2_vld), .hi_i(s2_hi), .lo_i(s2_lo), .ninv_i(s2_ninv),
    .vld_q(out_vld), .dout_q(out_byte)
  );

  a_r2_lat3: assert property (@(posedge clk) disable iff (rst) in_vld |=> ##2 out_vld);
  a_r1_zero: assert property (@(posedge clk) disable iff (rst)
               (out_vld && $past(in_vld, 3) && ($past(in_byte, 3) == 8'h00)) |-> (out_byte == 8'h63));
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (rst)
               (!out_vld && !s2_vld) |=> !out_vld);
endmodule

// File: tb/tb_sbox_tower_pipe.sv
`timescale 1ns/1ps
module tb_sbox_tower_pipe;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_vld;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  sbox_tower_pipe dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte),
    .out_vld(out_vld), .out_byte(out_byte)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic       ev [3] = '{1'b0, 1'b0, 1'b0};
  logic [7:0] ed [3] = '{8'h00, 8'h00, 8'h00};
  logic [7:0] last_out = 8'h00;

  // input byte in [15:8], known substitution in [7:0]
  localparam logic [15:0] VEC [8] = '{16'h0063, 16'h017C, 16'h10CA, 16'h53ED,
                                      16'h80CD, 16'hAAAC, 16'hC9DD, 16'hFF16};

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    logic [7:0] y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < 254; i++) r = gmul(r, a);
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] a);
    logic [7:0] b = ginv(a);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input string vtag, input string dtag);
    in_vld  = v;
    in_byte = d;
    @(posedge clk);
    if (rst) begin
      ev = '{1'b0, 1'b0, 1'b0};
      last_out = 8'h00;
    end else begin
      ev[2] = ev[1]; ev[1] = ev[0]; ev[0] = v;
      ed[2] = ed[1]; ed[1] = ed[0]; ed[0] = v ? ref_sbox(d) : 8'h00;
    end
    @(negedge clk);
    chk(vtag, {7'b0, out_vld}, {7'b0, ev[2]});
    if (ev[2]) begin
      chk(dtag, out_byte, ed[2]);
      last_out = ed[2];
    end else begin
      chk("R6", out_byte, last_out);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R5: reset state, valid low and byte zero
    repeat (3) step(1'b1, 8'h77, "R5", "R5");
    rst = 1'b0;

    // R1 and R7: known table walked back to back through the tower datapath
    for (int i = 0; i < 8; i++) begin
      chk("R1", ref_sbox(VEC[i][15:8]), VEC[i][7:0]);
      step(1'b1, VEC[i][15:8], "R4", "R7");
    end
    repeat (3) step(1'b0, 8'h5A, "R4", "R1");

    // R2: a lone byte after idle, valid only on the third edge
    step(1'b1, 8'h53, "R2", "R2");
    repeat (4) step(1'b0, 8'hFF, "R2", "R2");

    // R3: all 256 inputs at full rate, in order
    for (int i = 0; i < 256; i++) step(1'b1, 8'(i), "R3", "R3");
    repeat (3) step(1'b0, 8'h00, "R3", "R3");

    // R4 and R6: irregular bubbles with changing idle data
    for (int i = 0; i < 40; i++) step((i % 3) == 0 || (i % 7) == 5, 8'(i * 37 + 11), "R4", "R4");
    repeat (3) step(1'b0, 8'hC3, "R4", "R4");

    // R1: zero input
    step(1'b1, 8'h00, "R1", "R1");
    repeat (3) step(1'b0, 8'h9E, "R1", "R1");

    // R5: reset in the middle of a stream drops the bytes in flight
    step(1'b1, 8'h11, "R5", "R5");
    step(1'b1, 8'h22, "R5", "R5");
    rst = 1'b1;
    step(1'b1, 8'h33, "R5", "R5");
    rst = 1'b0;
    repeat (4) step(1'b0, 8'h44, "R5", "R5");
    step(1'b1, 8'hFF, "R5", "R1");
    repeat (3) step(1'b0, 8'h00, "R5", "R1");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule